// File: doc/BRIEF.md
# Six-Phase Block-Commutation Gate Driver

This block produces the six gate-drive signals of a three-phase motor bridge in 120-degree block commutation. Each applied step has exactly one high-side (positive) switch and one low-side (inverse) switch on, and the two are on different phases. Software first writes a 3-bit step code into a holding register. The code becomes the applied step only on a switch trigger, and only while the trigger-switch method is enabled. The applied code is visible on a status output.

At each step change, hardware enforces a dead time. When any output turns off, a timer starts. It loads the positive-side dead time if a high-side output fell, and the inverse-side dead time if a low-side output fell. Every output that the new step turns on is held low until all running timers have expired. Outputs that are on in both the old and the new step stay on without a gap. Two reserved codes switch the whole bridge off.

Top module: `bldc_commutator`

## Requirements
- R1: While `rst` is high at a clock edge, every gate output is low after that edge, and `pat_flags_o` reads 000.
- R2: A `pat_wr` pulse stores `pat_code` without changing any output. A trigger applies the code that was stored before that cycle, so a write in the same cycle as a trigger waits for the next trigger.
- R3: Gate bit layout: bits [2:0] are the positive outputs of phases U, V and W, and bits [5:3] are the inverse outputs of U, V and W. The valid codes select the following outputs: 001 selects U+ and V- (6'b010001); 010 selects V+ and W- (6'b100010); 011 selects U+ and W- (6'b100001); 100 selects W+ and U- (6'b001100); 101 selects W+ and V- (6'b010100); 110 selects V+ and U- (6'b001010).
- R4: Codes 000 and 111 drive all six outputs low from the edge at which they are applied.
- R5: When a positive output falls, the positive dead time `dt_pos`, sampled at that edge, is loaded. A newly selected output then rises exactly `dt_pos` edges after the fall.
- R6: When an inverse output falls, the inverse dead time `dt_neg`, sampled at that edge, is loaded and governs the rise in the same way.
- R7: With both dead times equal to zero, a newly selected output rises at the same edge at which the old one falls.
- R8: A new fall while a dead-time interval is running reloads the timer. Outputs still waiting stay low until the reloaded interval ends.
- R9: While `trig_mode_en` is low, `sw_trig` is ignored. The outputs and the flags keep their values.
- R10: `pat_flags_o` shows the applied code and changes only at an accepted trigger edge.
- R11: An output that is selected in both the old and the new step stays high through the switch.
- R12: A newly selected output waits while either timer is still running. When both sides fall together, it therefore waits the larger of the two dead times.
- R13: The positive and inverse outputs of a phase are never high together, and at most two outputs are high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; dead time counts its edges |
| rst | input | 1 | Synchronous reset, active high |
| pat_code | input | 3 | Step code to be stored |
| pat_wr | input | 1 | Store strobe for `pat_code` |
| trig_mode_en | input | 1 | Enables the trigger-switch method |
| sw_trig | input | 1 | Switch trigger pulse |
| dt_pos | input | DT_W | Dead time after a positive output falls, in clocks |
| dt_neg | input | DT_W | Dead time after an inverse output falls, in clocks |
| gate_o | output | 6 | Gate outputs, active high, layout as in R3 |
| pat_flags_o | output | 3 | Currently applied step code |

## Verification
Two events can fall in the same cycle. A trigger can arrive while a dead-time interval from an earlier switch is still counting, and a write can land in the same cycle as a trigger. The bench provokes the first by triggering again a few cycles into a dead time, and it expects the waiting outputs to rise one full reloaded interval after the second fall. It provokes the second by asserting `pat_wr` together with `sw_trig`, and it expects the previously stored code on the flags. Random stimulus that mixes writes, triggers, mode changes and dead-time values is compared every clock against a behavioural model.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;
    localparam int PHASES = 3;
    localparam int GATES  = 2 * PHASES;
    localparam int CODE_W = 3;
    localparam int GROUPS = 2;   // 0: positive side, 1: inverse side

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [GATES-1:0]  gates_t;

    typedef struct packed {
        code_t  pend;     // code written by software
        code_t  applied;  // code in force
        gates_t gate;     // registered gate outputs
    } comm_state_t;
endpackage

// File: rtl/comm_pattern_decode.sv
module comm_pattern_decode
    import bldc_comm_pkg::*;
(
    input  code_t  code_i,
    output gates_t gates_o
);
    // [2:0] = U+,V+,W+ ; [5:3] = U-,V-,W-
    always_comb begin
        case (code_i)
            3'b001:  gates_o = 6'b010_001;
            3'b010:  gates_o = 6'b100_010;
            3'b011:  gates_o = 6'b100_001;
            3'b100:  gates_o = 6'b001_100;
            3'b101:  gates_o = 6'b010_100;
            3'b110:  gates_o = 6'b001_010;
            default: gates_o = '0;
        endcase
    end
endmodule

// File: rtl/dead_time_timer.sv
module dead_time_timer #(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [DT_W-1:0] load_val,
    output logic            idle_next
);
    logic [DT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
        idle_next = (cnt_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_comm_pkg::*;
#(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      pat_code,
    input  logic            pat_wr,
    input  logic            trig_mode_en,
    input  logic            sw_trig,
    input  logic [DT_W-1:0] dt_pos,
    input  logic [DT_W-1:0] dt_neg,
    output logic [5:0]      gate_o,
    output logic [2:0]      pat_flags_o
);
    comm_state_t st_d, st_q;

    logic            take;
    code_t           next_code;
    gates_t          target;
    logic [GROUPS-1:0] fell;
    logic [GROUPS-1:0] idle;
    logic [DT_W-1:0] dt_sel [GROUPS];

    assign dt_sel[0] = dt_pos;
    assign dt_sel[1] = dt_neg;

    assign take      = sw_trig & trig_mode_en;
    assign next_code = take ? st_q.pend : st_q.applied;

    comm_pattern_decode u_dec (
        .code_i  (next_code),
        .gates_o (target)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_side
        assign fell[g] = |(st_q.gate[g*PHASES +: PHASES] & ~target[g*PHASES +: PHASES]);

        dead_time_timer #(.DT_W(DT_W)) u_tmr (
            .clk       (clk),
            .rst       (rst),
            .load      (fell[g]),
            .load_val  (dt_sel[g]),
            .idle_next (idle[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.applied = next_code;
        if (pat_wr)
            st_d.pend = pat_code;
        // held outputs stay on; new ones wait for every timer
        st_d.gate = target & (st_q.gate | {GATES{&idle}});
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gate_o      = st_q.gate;
    assign pat_flags_o = st_q.applied;
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk #(
    parameter int DT_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            trig_mode_en,
    input logic            sw_trig,
    input logic [DT_W-1:0] dt_pos,
    input logic [DT_W-1:0] dt_neg,
    input logic [5:0]      gate_o,
    input logic [2:0]      pat_flags_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (gate_o == 6'b0 && pat_flags_o == 3'b0));

    // R13
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ((gate_o[2:0] & gate_o[5:3]) == 3'b0) && ($countones(gate_o) <= 2));

    // R4
    reserved_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_flags_o == 3'b000 || pat_flags_o == 3'b111) |-> gate_o == 6'b0);

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(sw_trig && trig_mode_en) |=> $stable(pat_flags_o));

    // R12
    no_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(gate_o) & ~gate_o) && $past(dt_pos) != '0 && $past(dt_neg) != '0)
        |-> !(|(gate_o & ~$past(gate_o))));
endmodule

bind bldc_commutator bldc_commutator_chk #(.DT_W(DT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .trig_mode_en (trig_mode_en),
    .sw_trig      (sw_trig),
    .dt_pos       (dt_pos),
    .dt_neg       (dt_neg),
    .gate_o       (gate_o),
    .pat_flags_o  (pat_flags_o)
);

// File: tb/bldc_commutator_test.sv
module bldc_commutator_test;
    localparam int CLK_PERIOD = 10;
    localparam int DT_W = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      pat_code = '0;
    logic            pat_wr = 1'b0;
    logic            trig_mode_en = 1'b1;
    logic            sw_trig = 1'b0;
    logic [DT_W-1:0] dt_pos = '0;
    logic [DT_W-1:0] dt_neg = '0;
    logic [5:0]      gate_o;
    logic [2:0]      pat_flags_o;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bldc_commutator #(.DT_W(DT_W)) uut (
        .clk(clk), .rst(rst), .pat_code(pat_code), .pat_wr(pat_wr),
        .trig_mode_en(trig_mode_en), .sw_trig(sw_trig),
        .dt_pos(dt_pos), .dt_neg(dt_neg),
        .gate_o(gate_o), .pat_flags_o(pat_flags_o)
    );

    // R3 table as stated in the requirement
    function automatic logic [5:0] want(input int c);
        case (c)
            1: return 6'b010001;
            2: return 6'b100010;
            3: return 6'b100001;
            4: return 6'b001100;
            5: return 6'b010100;
            6: return 6'b001010;
            default: return 6'b0;
        endcase
    endfunction

    // behavioural reference
    int m_pend = 0, m_app = 0, m_wait_p = 0, m_wait_n = 0;
    logic [5:0] m_gate = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_app = 0; m_wait_p = 0; m_wait_n = 0; m_gate = '0;
        end else begin
            int nc;
            logic [5:0] sel;
            bit any_p, any_n;
            nc = (sw_trig && trig_mode_en) ? m_pend : m_app;
            sel = want(nc);
            any_p = 0; any_n = 0;
            for (int i = 0; i < 6; i++)
                if (m_gate[i] && !sel[i]) begin
                    if (i < 3) any_p = 1; else any_n = 1;
                end
            m_wait_p = any_p ? int'(dt_pos) : (m_wait_p > 0 ? m_wait_p - 1 : 0);
            m_wait_n = any_n ? int'(dt_neg) : (m_wait_n > 0 ? m_wait_n - 1 : 0);
            for (int i = 0; i < 6; i++)
                m_gate[i] = sel[i] && (m_gate[i] || (m_wait_p == 0 && m_wait_n == 0));
            if (pat_wr) m_pend = int'(pat_code);
            m_app = nc;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (gate_o !== m_gate || int'(pat_flags_o) != m_app) begin
                errors++;
                $display("FAIL R3/R5/R6/R8/R10 model: gate_o=%b flags=%0d expected gate=%b flags=%0d",
                         gate_o, pat_flags_o, m_gate, m_app);
            end
        end
    end

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual flags/gate=%b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] c);
        pat_code = c; pat_wr = 1'b1;
        @(negedge clk); pat_wr = 1'b0;
    endtask

    task automatic fire();
        sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic apply(input logic [2:0] c);
        wr(c); fire();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", {pat_flags_o, gate_o}, 9'b0);
        rst = 1'b0;
        model_on = 1'b1;
        dt_pos = 9; dt_neg = 4;

        wr(3'b001);
        repeat (2) @(negedge clk);
        chk("R2 write alone", {pat_flags_o, gate_o}, 9'b0);
        fire();
        chk("R3 code 001 no prior fall", {pat_flags_o, gate_o}, {3'b001, 6'b010001});

        apply(3'b011);   // V- falls -> dt_neg
        chk("R11 U+ kept", {pat_flags_o, gate_o}, {3'b011, 6'b000001});
        repeat (3) @(negedge clk);
        chk("R6 W- still held", {pat_flags_o, gate_o}, {3'b011, 6'b000001});
        @(negedge clk);
        chk("R6 W- after dt_neg", {pat_flags_o, gate_o}, {3'b011, 6'b100001});

        apply(3'b100);   // U+ and W- fall
        repeat (8) @(negedge clk);
        chk("R12 waits larger dt", {pat_flags_o, gate_o}, {3'b100, 6'b000000});
        @(negedge clk);
        chk("R12 rise after max", {pat_flags_o, gate_o}, {3'b100, 6'b001100});

        apply(3'b110);   // only W+ falls
        chk("R11 U- kept", {pat_flags_o, gate_o}, {3'b110, 6'b001000});
        repeat (8) @(negedge clk);
        chk("R5 V+ held", {pat_flags_o, gate_o}, {3'b110, 6'b001000});
        @(negedge clk);
        chk("R5 V+ after dt_pos", {pat_flags_o, gate_o}, {3'b110, 6'b001010});

        dt_pos = 0; dt_neg = 0;
        apply(3'b010);
        chk("R7 zero dead time", {pat_flags_o, gate_o}, {3'b010, 6'b100010});

        apply(3'b111);
        chk("R4 code 111", {pat_flags_o, gate_o}, {3'b111, 6'b0});
        apply(3'b000);
        chk("R4 code 000", {pat_flags_o, gate_o}, {3'b000, 6'b0});

        for (int c = 1; c < 7; c++) begin
            apply(3'b000);
            apply(3'(c));
            chk("R3 table", {pat_flags_o, gate_o}, {3'(c), want(c)});
        end

        trig_mode_en = 1'b0;
        wr(3'b001);
        fire(); fire();
        chk("R9 trigger ignored", {pat_flags_o, gate_o}, {3'b110, 6'b001010});
        trig_mode_en = 1'b1;
        fire();
        chk("R10 flags on accepted trigger", {pat_flags_o, gate_o}, {3'b001, 6'b010001});

        // R8: second fall inside a running interval
        dt_pos = 6; dt_neg = 6;
        apply(3'b011);   // V- falls, W- waits
        @(negedge clk);
        apply(3'b100);   // U+ falls, reload
        repeat (5) @(negedge clk);
        chk("R8 still held after reload", {pat_flags_o, gate_o}, {3'b100, 6'b0});
        @(negedge clk);
        chk("R8 rise after reloaded dt", {pat_flags_o, gate_o}, {3'b100, 6'b001100});

        // R2: write and trigger together
        dt_pos = 0; dt_neg = 0;
        wr(3'b101);
        pat_code = 3'b010; pat_wr = 1'b1; sw_trig = 1'b1;
        @(negedge clk); pat_wr = 1'b0; sw_trig = 1'b0;
        chk("R2 same-cycle write waits", {pat_flags_o, gate_o}, {3'b101, 6'b010100});
        fire();
        chk("R2 next trigger applies", {pat_flags_o, gate_o}, {3'b010, 6'b100010});

        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            pat_code     = 3'($urandom);
            pat_wr       = ($urandom % 3) == 0;
            sw_trig      = ($urandom % 5) == 0;
            trig_mode_en = ($urandom % 8) != 0;
            if (($urandom % 16) == 0) begin
                dt_pos = DT_W'($urandom % 12);
                dt_neg = DT_W'($urandom % 12);
            end
            @(negedge clk);
        end
        pat_wr = 1'b0; sw_trig = 1'b0;

        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset after run", {pat_flags_o, gate_o}, 9'b0);
        model_on = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule